// File: doc/BRIEF.md
# Serial LED Frame Shifter

This block sends a packed LED pattern to an enclosure LED controller over three wires: a serial clock, a load strobe and a data line. A host presents a pattern word that holds a fixed number of indicator signals for each drive port, then pulses `start`. The block captures the word and builds a slow, symmetric serial clock from the system clock. It then plays out one complete frame and goes back to idle.

Every frame has the same shape. First come a configurable number of idle clock slots. Next comes one slot with the load strobe high. Then the pattern bits follow, least significant bit first, one bit per slot. Last come a configurable number of idle trailing slots. `busy` covers the whole frame, and a one-cycle `done` pulse marks its end. A start request that arrives during a frame is dropped, so two frames never interleave.

Top module: `sgpio_led_shifter`

## Requirements
- R1: Out of reset, and whenever the block is not busy, `busy`, `done`, `ser_clk`, `ser_load` and `ser_data` are all 0.
- R2: Each serial clock slot drives `ser_clk` high for exactly HALF_CYC system cycles and then low for exactly HALF_CYC system cycles.
- R3: A frame begins with PRE_CLKS slots that have `ser_load` low and `ser_data` at 0.
- R4: After the leading slots comes exactly one slot with `ser_load` high and `ser_data` at 0. The strobe is stable while `ser_clk` is high and is low again before the first data bit.
- R5: After the load slot, SIG_PER_PORT*N_PORTS data slots follow. Data slot k carries bit k of the pattern that was captured at start, with bit 0 first.
- R6: After the last data bit come POST_CLKS slots with `ser_load` low. During these slots `ser_data` keeps the last data bit.
- R7: `busy` rises on the first clock edge that samples `start` while idle. It stays high for exactly (PRE_CLKS+1+SIG_PER_PORT*N_PORTS+POST_CLKS)*2*HALF_CYC cycles.
- R8: `done` is high for one system cycle. That cycle is the first cycle after `busy` falls.
- R9: A `start` pulse while busy is ignored: the frame in progress is unchanged and ends with a single `done`. A change of `pattern` during a frame is ignored in the same way.
- R10: A `start` sampled in the `done` cycle is accepted at once, so frames can run back to back.
- R11: `ser_data` changes only at slot boundaries and is stable while `ser_clk` is high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| start | input | 1 | Request to send one frame; taken only when idle |
| pattern | input | SIG_PER_PORT*N_PORTS | LED pattern word, captured at start |
| busy | output | 1 | Frame in progress |
| done | output | 1 | One-cycle pulse after the last trailing slot |
| ser_clk | output | 1 | Serial LED clock |
| ser_load | output | 1 | Serial load strobe |
| ser_data | output | 1 | Serial data line |

## Verification
The hardest case to reach is a start request at the exact boundary of a frame. This covers a request during the final low half of the last trailing slot and a request in the single cycle when `done` is high. The bench waits at falling edges until `done` is seen and then raises `start` in that same cycle, so the second frame must begin with no gap. A separate scenario pulses `start` and changes `pattern` in the middle of the data phase. It then checks that the captured bit stream still matches the first word and that exactly one `done` appears.

// File: rtl/sled_pkg.sv
package sled_pkg;

   typedef enum logic [2:0] {
      PH_IDLE = 3'd0,
      PH_LEAD = 3'd1,
      PH_MARK = 3'd2,
      PH_BITS = 3'd3,
      PH_TAIL = 3'd4
   } sled_phase_e;

   function automatic int unsigned max3(input int unsigned a, input int unsigned b,
                                        input int unsigned c);
      int unsigned m;
      m = (a > b) ? a : b;
      return (m > c) ? m : c;
   endfunction

endpackage

// File: rtl/sled_halfclk.sv
module sled_halfclk #(
   parameter int unsigned HALF_CYC = 5000
) (
   input  logic clk,
   input  logic rst_n,
   input  logic run,
   output logic sclk_level,
   output logic slot_end
);
   localparam int unsigned CW = $clog2(HALF_CYC + 1);
   localparam logic [CW-1:0] LAST = CW'(HALF_CYC - 1);

   logic [CW-1:0] cnt_q;
   logic          low_q;
   logic          half_end;

   assign half_end   = run && (cnt_q == LAST);
   assign slot_end   = half_end && low_q;
   assign sclk_level = run && !low_q;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         cnt_q <= '0;
         low_q <= 1'b0;
      end else if (!run) begin
         cnt_q <= '0;
         low_q <= 1'b0;
      end else if (half_end) begin
         cnt_q <= '0;
         low_q <= ~low_q;
      end else begin
         cnt_q <= cnt_q + 1'b1;
      end
   end
endmodule

// File: rtl/sled_seq.sv
module sled_seq
   import sled_pkg::*;
#(
   parameter int unsigned PRE_CLKS  = 2,
   parameter int unsigned NBITS     = 12,
   parameter int unsigned POST_CLKS = 2
) (
   input  logic        clk,
   input  logic        rst_n,
   input  logic        start,
   input  logic        slot_end,
   output sled_phase_e phase,
   output logic        accept,
   output logic        take_bit,
   output logic        finish,
   output logic        done
);
   localparam int unsigned MAXC  = max3(PRE_CLKS, NBITS, POST_CLKS);
   localparam int unsigned CW    = $clog2(MAXC + 1);
   localparam logic [CW-1:0] PRE_LAST  = CW'((PRE_CLKS  > 0) ? PRE_CLKS  - 1 : 0);
   localparam logic [CW-1:0] BIT_LAST  = CW'(NBITS - 1);
   localparam logic [CW-1:0] POST_LAST = CW'((POST_CLKS > 0) ? POST_CLKS - 1 : 0);

   sled_phase_e   ph_q, ph_d;
   logic [CW-1:0] cnt_q, cnt_d;
   logic          done_q;
   sled_phase_e   first_ph;
   sled_phase_e   after_bits;

   generate
      if (PRE_CLKS > 0) begin : g_lead
         assign first_ph = PH_LEAD;
      end else begin : g_nolead
         assign first_ph = PH_MARK;
      end
      if (POST_CLKS > 0) begin : g_tail
         assign after_bits = PH_TAIL;
      end else begin : g_notail
         assign after_bits = PH_IDLE;
      end
   endgenerate

   assign accept = (ph_q == PH_IDLE) && start;

   always_comb begin
      ph_d     = ph_q;
      cnt_d    = cnt_q;
      take_bit = 1'b0;
      finish   = 1'b0;
      if (accept) begin
         ph_d  = first_ph;
         cnt_d = '0;
      end else if (slot_end) begin
         unique case (ph_q)
            PH_LEAD: begin
               if (cnt_q == PRE_LAST) begin
                  ph_d  = PH_MARK;
                  cnt_d = '0;
               end else begin
                  cnt_d = cnt_q + 1'b1;
               end
            end
            PH_MARK: begin
               ph_d     = PH_BITS;
               cnt_d    = '0;
               take_bit = 1'b1;
            end
            PH_BITS: begin
               if (cnt_q == BIT_LAST) begin
                  ph_d   = after_bits;
                  cnt_d  = '0;
                  finish = (after_bits == PH_IDLE);
               end else begin
                  cnt_d    = cnt_q + 1'b1;
                  take_bit = 1'b1;
               end
            end
            PH_TAIL: begin
               if (cnt_q == POST_LAST) begin
                  ph_d   = PH_IDLE;
                  cnt_d  = '0;
                  finish = 1'b1;
               end else begin
                  cnt_d = cnt_q + 1'b1;
               end
            end
            default: begin
               ph_d  = PH_IDLE;
               cnt_d = '0;
            end
         endcase
      end
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         ph_q   <= PH_IDLE;
         cnt_q  <= '0;
         done_q <= 1'b0;
      end else begin
         ph_q   <= ph_d;
         cnt_q  <= cnt_d;
         done_q <= finish;
      end
   end

   assign phase = ph_q;
   assign done  = done_q;
endmodule

// File: rtl/sled_shift.sv
module sled_shift #(
   parameter int unsigned NBITS = 12
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             load,
   input  logic [NBITS-1:0] pattern,
   input  logic             take_bit,
   input  logic             clear,
   output logic             sdata
);
   logic [NBITS-1:0] sh_q;
   logic             d_q;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         sh_q <= '0;
         d_q  <= 1'b0;
      end else begin
         if (load) begin
            sh_q <= pattern;
         end else if (take_bit) begin
            sh_q <= sh_q >> 1;
         end
         if (clear) begin
            d_q <= 1'b0;
         end else if (take_bit) begin
            d_q <= sh_q[0];
         end
      end
   end

   assign sdata = d_q;
endmodule

// File: rtl/sgpio_led_shifter.sv
module sgpio_led_shifter
   import sled_pkg::*;
#(
   parameter int unsigned HALF_CYC     = 5000,
   parameter int unsigned SIG_PER_PORT = 3,
   parameter int unsigned N_PORTS      = 4,
   parameter int unsigned PRE_CLKS     = 2,
   parameter int unsigned POST_CLKS    = 2,
   localparam int unsigned NBITS       = SIG_PER_PORT * N_PORTS
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             start,
   input  logic [NBITS-1:0] pattern,
   output logic             busy,
   output logic             done,
   output logic             ser_clk,
   output logic             ser_load,
   output logic             ser_data
);
   generate
      if (HALF_CYC < 1) begin : g_bad_half
         $error("HALF_CYC must be at least 1");
      end
      if (SIG_PER_PORT < 1) begin : g_bad_sig
         $error("SIG_PER_PORT must be at least 1");
      end
      if (N_PORTS < 1 || N_PORTS > 8) begin : g_bad_ports
         $error("N_PORTS must be in 1..8");
      end
   endgenerate

   sled_phase_e phase;
   logic        run;
   logic        slot_end;
   logic        accept;
   logic        take_bit;
   logic        finish;

   assign run = (phase != PH_IDLE);

   sled_halfclk #(.HALF_CYC(HALF_CYC)) u_halfclk (
      .clk        (clk),
      .rst_n      (rst_n),
      .run        (run),
      .sclk_level (ser_clk),
      .slot_end   (slot_end)
   );

   sled_seq #(.PRE_CLKS(PRE_CLKS), .NBITS(NBITS), .POST_CLKS(POST_CLKS)) u_seq (
      .clk      (clk),
      .rst_n    (rst_n),
      .start    (start),
      .slot_end (slot_end),
      .phase    (phase),
      .accept   (accept),
      .take_bit (take_bit),
      .finish   (finish),
      .done     (done)
   );

   sled_shift #(.NBITS(NBITS)) u_shift (
      .clk      (clk),
      .rst_n    (rst_n),
      .load     (accept),
      .pattern  (pattern),
      .take_bit (take_bit),
      .clear    (finish),
      .sdata    (ser_data)
   );

   assign busy     = run;
   assign ser_load = (phase == PH_MARK);
endmodule

// File: rtl/sled_shifter_chk.sv
module sled_shifter_chk #(
   parameter int unsigned HALF_CYC = 5000
) (
   input logic clk,
   input logic rst_n,
   input logic start,
   input logic busy,
   input logic done,
   input logic ser_clk,
   input logic ser_load,
   input logic ser_data
);
   localparam int unsigned CW = $clog2(HALF_CYC + 2);
   logic [CW-1:0] hi_cnt;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)       hi_cnt <= '0;
      else if (ser_clk) hi_cnt <= hi_cnt + 1'b1;
      else              hi_cnt <= '0;
   end

   // R1
   a_r1_idle_quiet: assert property (@(posedge clk) disable iff (!rst_n)
      !busy |-> (!ser_clk && !ser_load && !ser_data));

   // R2
   a_r2_high_width: assert property (@(posedge clk) disable iff (!rst_n)
      $fell(ser_clk) |-> (hi_cnt == CW'(HALF_CYC)));

   // R4
   a_r4_load_steady: assert property (@(posedge clk) disable iff (!rst_n)
      (ser_clk && $past(ser_clk)) |-> $stable(ser_load));

   // R11
   a_r11_data_steady: assert property (@(posedge clk) disable iff (!rst_n)
      (ser_clk && $past(ser_clk)) |-> $stable(ser_data));

   // R8
   a_r8_done_after_busy: assert property (@(posedge clk) disable iff (!rst_n)
      done |-> (!busy && $past(busy)));

   // R7
   a_r7_start_begins: assert property (@(posedge clk) disable iff (!rst_n)
      (!busy && start) |=> (busy && ser_clk));
endmodule

bind sgpio_led_shifter sled_shifter_chk #(.HALF_CYC(HALF_CYC)) u_chk (
   .clk      (clk),
   .rst_n    (rst_n),
   .start    (start),
   .busy     (busy),
   .done     (done),
   .ser_clk  (ser_clk),
   .ser_load (ser_load),
   .ser_data (ser_data)
);

// File: tb/sgpio_led_shifter_tb.sv
`timescale 1ns/1ps
module sgpio_led_shifter_tb;
   localparam int H     = 3;
   localparam int SIG   = 3;
   localparam int PORTS = 4;
   localparam int PRE   = 2;
   localparam int POST  = 3;
   localparam int NB    = SIG * PORTS;
   localparam int SLOTS = PRE + 1 + NB + POST;
   localparam int FRAME_CYC = SLOTS * 2 * H;

   logic clk = 1'b0;
   logic rst_n = 1'b0;
   logic start = 1'b0;
   logic [NB-1:0] pattern = '0;
   logic busy, done, ser_clk, ser_load, ser_data;

   int checks = 0;
   int fails  = 0;

   always #5 clk = ~clk;

   sgpio_led_shifter #(.HALF_CYC(H), .SIG_PER_PORT(SIG), .N_PORTS(PORTS),
                       .PRE_CLKS(PRE), .POST_CLKS(POST)) u_dut (
      .clk(clk), .rst_n(rst_n), .start(start), .pattern(pattern),
      .busy(busy), .done(done), .ser_clk(ser_clk), .ser_load(ser_load),
      .ser_data(ser_data)
   );

   // monitor, samples 2 ns after each rising edge
   logic cap_load [0:63];
   logic cap_data [0:63];
   int   ncap = 0, busy_cnt = 0, done_cnt = 0, width_err = 0, idle_err = 0;
   int   hi_run = 0, lo_run = 0;
   logic prev_clk = 1'b0, prev_busy = 1'b0;

   always @(posedge clk) begin
      #2;
      if (rst_n) begin
         if (busy) busy_cnt++;
         if (done) done_cnt++;
         if (!busy && (ser_clk || ser_load || ser_data)) idle_err++;
         if (ser_clk && !prev_clk) begin
            if (lo_run != 0 && lo_run != H) width_err++;
            lo_run = 0;
            if (ncap < 64) begin
               cap_load[ncap] = ser_load;
               cap_data[ncap] = ser_data;
            end
            ncap++;
         end
         if (!ser_clk && prev_clk) begin
            if (hi_run != H) width_err++;
            hi_run = 0;
         end
         if (!busy && prev_busy) begin
            if (lo_run != H) width_err++;
            lo_run = 0;
         end
         if (ser_clk) hi_run++;
         else if (busy) lo_run++;
         prev_clk  = ser_clk;
         prev_busy = busy;
      end
   end

   task automatic check(input bit ok, input string req, input int act, input int exp);
      checks++;
      if (!ok) begin
         fails++;
         $display("FAIL %s: actual %0d expected %0d", req, act, exp);
      end
   endtask

   // caller is at a falling edge
   task automatic start_frame(input logic [NB-1:0] p);
      ncap = 0; busy_cnt = 0; done_cnt = 0; width_err = 0;
      pattern = p;
      start = 1'b1;
      @(negedge clk);
      start = 1'b0;
   endtask

   // returns at the falling edge inside the done cycle
   task automatic finish_frame(input logic [NB-1:0] p, input string tag);
      int guard = 0;
      int bad_lead = 0, bad_mark = 0, bad_bits = 0, bad_tail = 0;
      while (done_cnt == 0 && guard < 10 * FRAME_CYC) begin
         @(negedge clk);
         guard++;
      end
      check(done_cnt == 1, {"R8 done seen ", tag}, done_cnt, 1);
      check(ncap == SLOTS, {"R5 slot count ", tag}, ncap, SLOTS);
      check(busy_cnt == FRAME_CYC, {"R7 busy length ", tag}, busy_cnt, FRAME_CYC);
      check(width_err == 0, {"R2 clock halves ", tag}, width_err, 0);
      if (ncap == SLOTS) begin
         for (int i = 0; i < PRE; i++)
            if (cap_load[i] || cap_data[i]) bad_lead++;
         if (!cap_load[PRE] || cap_data[PRE]) bad_mark++;
         for (int i = 0; i < NB; i++)
            if (cap_load[PRE+1+i] || cap_data[PRE+1+i] !== p[i]) bad_bits++;
         for (int i = 0; i < POST; i++)
            if (cap_load[PRE+1+NB+i] || cap_data[PRE+1+NB+i] !== p[NB-1]) bad_tail++;
      end
      check(bad_lead == 0, {"R3 leading slots ", tag}, bad_lead, 0);
      check(bad_mark == 0, {"R4 load slot ", tag}, bad_mark, 0);
      check(bad_bits == 0, {"R5 data bits LSB first ", tag}, bad_bits, 0);
      check(bad_tail == 0, {"R6 trailing slots hold last bit ", tag}, bad_tail, 0);
   endtask

   task automatic t_reset();
      check(!busy && !done && !ser_clk && !ser_load && !ser_data,
            "R1 reset outputs", {busy, done, ser_clk, ser_load, ser_data}, 0);
   endtask

   task automatic t_frame(input logic [NB-1:0] p, input string tag);
      start_frame(p);
      finish_frame(p, tag);
      @(negedge clk);
      check(!done, {"R8 done single cycle ", tag}, done, 0);
      check(idle_err == 0, {"R1 idle quiet ", tag}, idle_err, 0);
      repeat (4) @(negedge clk);
   endtask

   task automatic t_start_busy();
      logic [NB-1:0] p = 12'h3C6;
      start_frame(p);
      repeat ((PRE + 4) * 2 * H) @(negedge clk);
      pattern = ~p;
      start = 1'b1;
      @(negedge clk);
      start = 1'b0;
      finish_frame(p, "R9 start while busy");
      repeat (3 * FRAME_CYC) @(negedge clk);
      check(done_cnt == 1 && !busy, "R9 no extra frame", done_cnt, 1);
   endtask

   task automatic t_back_to_back();
      start_frame(12'h5A1);
      finish_frame(12'h5A1, "b2b first");
      start_frame(12'hC3E);
      check(busy == 1'b1, "R10 start in done cycle accepted", busy, 1);
      finish_frame(12'hC3E, "R10 b2b second");
      repeat (4) @(negedge clk);
   endtask

   initial begin
      #(20 * FRAME_CYC * 20 * 10);
      fails++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
      $finish;
   end

   initial begin
      repeat (3) @(negedge clk);
      t_reset();
      rst_n = 1'b1;
      repeat (2) @(negedge clk);
      t_reset();
      t_frame(12'hA5C, "mixed");
      t_frame(12'hFFF, "ones");
      t_frame(12'h001, "lsb only");
      t_frame(12'h800, "msb only");
      t_start_busy();
      t_back_to_back();
      check(idle_err == 0, "R11 R1 idle data low", idle_err, 0);
      $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
      $finish;
   end
endmodule